// File: doc/BRIEF.md
# Fractional-Divider Timebase Counter

This block is a single timebase shared by several PWM channels. A reference clock enable drives a rate divider whose divisor has an integer part and a fractional part. Each divided tick moves a counter of up to 14 bits one step forward. The channels compare their thresholds against this count.

The fractional part feeds an accumulator. Whenever the accumulator carries, the next divided period is one reference cycle longer. Over many periods this gives an average tick rate equal to the reference rate divided by the full divisor. The counter wraps to zero at a limit set by a resolution field. On the cycle it reads zero after a wrap, it raises an overflow strobe for one clock.

A pause input freezes both the counter and the divider state. A synchronous clear input returns the count, the divider position and the accumulator to zero.

The divider is a two-phase state machine:
- PH_BASE counts the integer part in reference cycles.
- PH_EXTRA is the single inserted cycle that follows a carry.

The transitions are:
- BASE→BASE: the period ends with no carry pending, and the block ticks.
- BASE→EXTRA: the period ends with a carry pending, and no tick is issued yet.
- EXTRA→BASE: the block ticks on the next reference cycle.

Top module: `frac_timebase`

## Requirements
- R1: After rst_n is low, or after an edge with sync_clr high, count is 0 and ovf is 0. The divider position and the accumulator are also zero, so the first period after a clear lasts exactly the integer part in reference cycles.
- R2: The count changes only at an edge where ref_en is 1 and pause is 0. Cycles with ref_en low leave count unchanged.
- R3: The divisor div_val holds the integer part in bits [17:8]. For div_val = N·256 with N ≥ 1, the count advances once per N accepted reference cycles. The first advance comes on the Nth one after a clear.
- R4: The fraction div_val[7:0] is added to an 8-bit accumulator at each tick. When that addition carries out of bit 7, the following period lasts N+1 reference cycles. A divisor of 2.5 (0x280) therefore gives periods of 2, 2, 3, 2, 3, … cycles.
- R5: An integer part of 0 is treated as 1.
- R6: The wrap limit is 2^r − 1, where r is the 4-bit field res_sel. A value of 0 is treated as 1, and values above 14 are treated as 14.
- R7: A tick at a count that has reached the limit sets count to 0. ovf is then 1 for exactly the one clock in which count first reads 0, and 0 at all other times.
- R8: While pause is 1, reference cycles are not counted. After pause is released, the divider finishes the period that was in progress.
- R9: If res_sel is lowered below the present count, the next tick wraps the count to 0 and raises ovf.
- R10: Apart from clear and wrap, each tick raises the count by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_en | input | 1 | Reference clock enable, one pulse per reference cycle |
| div_val | input | 18 | Divisor: integer part [17:8], fraction [7:0] |
| res_sel | input | 4 | Counter resolution in bits (1..14, clamped) |
| pause | input | 1 | Freeze count and divider |
| sync_clr | input | 1 | Synchronous clear of count, divider and accumulator |
| count | output | 14 | Timebase count |
| ovf | output | 1 | One-clock strobe after each wrap |

## Verification
The checker watches the following on every clock:
- a clear always leaves the count at zero with ovf low;
- idle and paused cycles never move the count;
- the count moves only by one step or back to zero;
- ovf lasts one clock, and is raised exactly when a nonzero count returns to zero.

Some properties depend on counting reference cycles across whole periods, so only the bench scenarios can show them:
- the divided tick rate for integer and fractional divisors, including the inserted extra cycles;
- the clamping of the resolution field;
- resumption partway through a period after a pause;
- the clearing of a pending carry.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

    // Divider phase: integer portion of a period, or the one inserted cycle
    typedef enum logic [0:0] {
        PH_BASE  = 1'b0,
        PH_EXTRA = 1'b1
    } div_phase_e;

endpackage

// File: rtl/ftb_divider.sv
module ftb_divider
    import ftb_pkg::*;
#(
    parameter int INT_W  = 10,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_clr,
    input  logic              ref_en,
    input  logic              pause,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);

    div_phase_e          phase_q, phase_d;
    logic [INT_W-1:0]    base_cnt_q;
    logic [FRAC_W-1:0]   acc_q;
    logic                extra_q;

    logic                go;
    logic [INT_W-1:0]    int_eff;
    logic [INT_W-1:0]    int_last;
    logic                base_done;
    logic [FRAC_W:0]     acc_sum;

    // An accepted reference cycle
    assign go = ref_en && !pause;

    // Integer part of zero behaves like one (R5)
    assign int_eff   = (div_int == '0) ? INT_W'(1) : div_int;
    assign int_last  = int_eff - INT_W'(1);
    assign base_done = (base_cnt_q >= int_last);
    assign acc_sum   = {1'b0, acc_q} + {1'b0, div_frac};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_BASE;
        end else if (sync_clr) begin
            phase_q <= PH_BASE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Next-state logic
    always_comb begin
        phase_d = phase_q;
        if (go) begin
            unique case (phase_q)
                PH_BASE: begin
                    if (base_done && extra_q) begin
                        phase_d = PH_EXTRA;
                    end
                end
                PH_EXTRA: begin
                    phase_d = PH_BASE;
                end
            endcase
        end
    end

    // Output logic
    always_comb begin
        tick = 1'b0;
        if (go) begin
            unique case (phase_q)
                PH_BASE:  tick = base_done && !extra_q;
                PH_EXTRA: tick = 1'b1;
            endcase
        end
    end

    // Period position counter and fractional accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_cnt_q <= '0;
            acc_q      <= '0;
            extra_q    <= 1'b0;
        end else if (sync_clr) begin
            base_cnt_q <= '0;
            acc_q      <= '0;
            extra_q    <= 1'b0;
        end else begin
            if (go && (phase_q == PH_BASE)) begin
                base_cnt_q <= base_done ? '0 : base_cnt_q + INT_W'(1);
            end
            if (tick) begin
                acc_q   <= acc_sum[FRAC_W-1:0];
                extra_q <= acc_sum[FRAC_W];
            end
        end
    end

endmodule

// File: rtl/ftb_limit.sv
module ftb_limit #(
    parameter int CNT_W = 14,
    parameter int RES_W = 4
) (
    input  logic [RES_W-1:0] res_sel,
    output logic [CNT_W-1:0] max_val
);

    logic [RES_W-1:0] res_eff;

    // Clamp resolution into 1..CNT_W (R6)
    always_comb begin
        if (res_sel == '0) begin
            res_eff = RES_W'(1);
        end else if (32'(res_sel) > CNT_W) begin
            res_eff = RES_W'(CNT_W);
        end else begin
            res_eff = res_sel;
        end
    end

    // Limit is a low-order mask of res_eff ones
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign max_val[i] = (32'(res_eff) > i);
    end

endmodule

// File: rtl/ftb_counter.sv
module ftb_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] max_val,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             at_limit;

    // ">=" so that a lowered limit still wraps (R9)
    assign at_limit = (cnt_q >= max_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (sync_clr) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= at_limit ? '0 : cnt_q + CNT_W'(1);
            ovf_q <= at_limit;
        end else begin
            ovf_q <= 1'b0;
        end
    end

    assign count = cnt_q;
    assign ovf   = ovf_q;

endmodule

// File: rtl/frac_timebase.sv
module frac_timebase #(
    parameter int INT_W  = 10,
    parameter int FRAC_W = 8,
    parameter int CNT_W  = 14,
    localparam int DIV_W = INT_W + FRAC_W,
    localparam int RES_W = $clog2(CNT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic [DIV_W-1:0] div_val,
    input  logic [RES_W-1:0] res_sel,
    input  logic             pause,
    input  logic             sync_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    logic             tick;
    logic [CNT_W-1:0] max_val;

    ftb_divider #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_clr (sync_clr),
        .ref_en   (ref_en),
        .pause    (pause),
        .div_int  (div_val[DIV_W-1:FRAC_W]),
        .div_frac (div_val[FRAC_W-1:0]),
        .tick     (tick)
    );

    ftb_limit #(
        .CNT_W (CNT_W),
        .RES_W (RES_W)
    ) u_lim (
        .res_sel (res_sel),
        .max_val (max_val)
    );

    ftb_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_clr (sync_clr),
        .tick     (tick),
        .max_val  (max_val),
        .count    (count),
        .ovf      (ovf)
    );

endmodule

// File: rtl/ftb_checker.sv
module ftb_checker #(
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_en,
    input logic             pause,
    input logic             sync_clr,
    input logic [CNT_W-1:0] count,
    input logic             ovf
);

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> (count == '0 && !ovf));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_clr && (!ref_en || pause)) |=> ($stable(count) && !ovf));

    assert_pause_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !sync_clr) |=> $stable(count));

    assert_ovf_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !ovf);

    assert_ovf_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (count == '0));

    assert_wrap_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_clr |=> (ovf == (count == '0 && $past(count) != '0)));

    assert_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_clr |=> (count == $past(count) || count == $past(count) + CNT_W'(1)
                       || count == '0));

endmodule

bind frac_timebase ftb_checker #(.CNT_W(CNT_W)) u_ftb_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_en   (ref_en),
    .pause    (pause),
    .sync_clr (sync_clr),
    .count    (count),
    .ovf      (ovf)
);

// File: tb/tb_frac_timebase.sv
`timescale 1ns/1ps
module tb_frac_timebase;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_en = 1'b0;
    logic [17:0] div_val = 18'h00100;
    logic [3:0]  res_sel = 4'd14;
    logic        pause = 1'b0;
    logic        sync_clr = 1'b0;
    logic [13:0] count;
    logic        ovf;

    int n_checks = 0;
    int n_fail   = 0;
    int ovf_seen = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    frac_timebase dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_en   (ref_en),
        .div_val  (div_val),
        .res_sel  (res_sel),
        .pause    (pause),
        .sync_clr (sync_clr),
        .count    (count),
        .ovf      (ovf)
    );

    typedef struct packed {
        logic [17:0] div;
        logic [3:0]  res;
        logic [15:0] refs;
        logic [13:0] cnt;
        logic [7:0]  ovfs;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{18'h00100, 4'd14, 16'd10,    14'd10,    8'd0, 4'd3}, // R3 divide by 1
        '{18'h00300, 4'd14, 16'd10,    14'd3,     8'd0, 4'd3}, // R3 divide by 3
        '{18'h00280, 4'd14, 16'd12,    14'd5,     8'd0, 4'd4}, // R4 2.5: 2,2,3,2,3
        '{18'h00140, 4'd14, 16'd10,    14'd8,     8'd0, 4'd4}, // R4 1.25
        '{18'h00080, 4'd14, 16'd10,    14'd7,     8'd0, 4'd5}, // R5 0.5 acts as 1.5
        '{18'h00100, 4'd3,  16'd20,    14'd4,     8'd2, 4'd7}, // R7 wrap at 7
        '{18'h00100, 4'd0,  16'd5,     14'd1,     8'd2, 4'd6}, // R6 res 0 -> 1
        '{18'h00100, 4'd15, 16'd16384, 14'd0,     8'd1, 4'd6}, // R6 res 15 -> 14
        '{18'h00100, 4'd14, 16'd16383, 14'd16383, 8'd0, 4'd6}, // R6 full 14-bit
        '{18'h00200, 4'd2,  16'd17,    14'd0,     8'd2, 4'd7}, // R7 wrap at 3
        '{18'h3FFFF, 4'd14, 16'd1023,  14'd1,     8'd0, 4'd3}  // R3 largest integer part
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        sync_clr = 1'b1;
        @(negedge clk);
        sync_clr = 1'b0;
        ovf_seen = 0;
    endtask

    task automatic run_refs(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ovf) ovf_seen++;
            ref_en = 1'b1;
        end
        @(negedge clk);
        if (ovf) ovf_seen++;
        ref_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog R1..all actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 count in reset", count, 0);
        check("R1 ovf in reset", ovf, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 count after reset", count, 0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            div_val = VECS[v].div;
            res_sel = VECS[v].res;
            do_clear();
            run_refs(int'(VECS[v].refs));
            check($sformatf("R%0d vec%0d count", VECS[v].req, v), count, int'(VECS[v].cnt));
            check($sformatf("R%0d vec%0d ovf pulses", VECS[v].req, v), ovf_seen, int'(VECS[v].ovfs));
        end

        // R7: strobe width and alignment with zero
        div_val = 18'h00100; res_sel = 4'd2;
        do_clear();
        run_refs(3);
        check("R7 count at limit", count, 3);
        ref_en = 1'b1;
        @(negedge clk);
        ref_en = 1'b0;
        check("R7 ovf raised", ovf, 1);
        check("R7 count zero with ovf", count, 0);
        @(negedge clk);
        check("R7 ovf one clock", ovf, 0);

        // R8: pause mid-period, then resume
        div_val = 18'h00300; res_sel = 4'd14;
        do_clear();
        run_refs(2);
        check("R8 before pause", count, 0);
        pause = 1'b1;
        run_refs(5);
        check("R8 frozen while paused", count, 0);
        pause = 1'b0;
        run_refs(1);
        check("R8 resumes period", count, 1);
        // R2: idle cycles
        repeat (4) @(negedge clk);
        check("R2 idle hold", count, 1);

        // R1: clear mid-period
        do_clear();
        run_refs(2);
        do_clear();
        run_refs(2);
        check("R1 divider cleared", count, 0);
        run_refs(1);
        check("R1 first tick after clear", count, 1);

        // R1: clear drops pending carry
        div_val = 18'h00280;
        do_clear();
        run_refs(4);
        check("R4 two ticks", count, 2);
        do_clear();
        run_refs(2);
        check("R1 carry cleared", count, 1);

        // R9: lowered resolution
        div_val = 18'h00100; res_sel = 4'd14;
        do_clear();
        run_refs(10);
        check("R10 count ten", count, 10);
        res_sel = 4'd2;
        ovf_seen = 0;
        run_refs(1);
        check("R9 wrap below count", count, 0);
        check("R9 ovf on wrap", ovf_seen, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule